// File: doc/BRIEF.md
# Time-Shared Two-Pass Transform Scheduler

This block lets one 8-point 1D inverse-transform datapath do both passes of an 8x8 2D inverse transform. The datapath is split into an even half and an odd half. The block alternates which pass feeds which half on every cycle. In a phase-0 cycle the even half takes the even-indexed words of a new first-pass row, while the odd half takes the odd-indexed words of a second-pass column. In a phase-1 cycle the roles swap: the odd half takes the odd words of the row accepted one phase earlier, and the even half takes the even words of the next column read out of the transpose buffer. Both halves therefore stay busy whenever both passes have work, and neither pass waits for the other to finish.

First-pass results come back on the feedback port as whole rows. They are written row by row into one bank of a two-bank transpose buffer. Once a bank holds eight rows it becomes readable and is read column by column, while the other bank takes the next block. Rows enter on a valid/ready stream: a row is taken only in a cycle where both `in_valid` and `in_ready` are high, and `in_valid` with `in_ready` low has no effect. The operand outputs and the feedback input carry valid flags but no back-pressure, because the datapath behind them has a fixed latency and always accepts. The dimension selects tell the datapath which pass each half is working on at each of its three pipeline stages.

Top module: `twopass_sched`

## Requirements
- R1: After reset `in_ready` is 1, `ev_valid` and `od_valid` are 0, and `dim_sel` is 0.
- R2: In a cycle with `dim_sel[0]`=0, `ev_data` lane k carries word 2k of `in_row`, and `ev_valid` is high exactly when that row is accepted. `od_data` lane k carries row 2k+1 of the column read in the previous cycle, and `od_valid` is high when such a column is pending.
- R3: In a cycle with `dim_sel[0]`=1, `od_data` lane k carries word 2k+1 of the row accepted in the last phase-0 cycle, and `od_valid` marks it. `ev_data` lane k carries row 2k of the next unread column of the readable bank, and `ev_valid` marks it.
- R4: `in_ready` is high only while `dim_sel[0]` is 0. Every accepted row reaches the datapath exactly once, in order, even half first and then odd half.
- R5: Within a block, column c of the transpose buffer holds word c of each of the 8 fed-back rows, with the first fed-back row at row index 0. Columns are issued to the datapath in order 0 to 7, and blocks in arrival order.
- R6: Two banks are used in ping-pong. Block n+1 may be accepted while block n is still read. The first row of a block is held off until a bank is free, so a block's first row is accepted only after all columns of the block two earlier have been issued.
- R7: While there is work, `dim_sel[0]` toggles every cycle: any cycle with a valid operand is followed by the opposite phase, unless `blk_start` is high. With no row offered, no row held and no column pending, the phase holds at 0.
- R8: A `blk_start` pulse makes the next cycle phase 0 (`dim_sel[0]`=0), with no row or column lost or repeated.
- R9: `dim_sel[1]` and `dim_sel[2]` equal `dim_sel[0]` delayed by one and by two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Phase realignment pulse |
| in_valid | input | 1 | First-pass row offered |
| in_ready | output | 1 | Row can be accepted this cycle |
| in_row | input | NPT*WID | First-pass row, word k in slice k |
| fb_valid | input | 1 | First-pass result row from datapath |
| fb_row | input | NPT*WID | First-pass result row, natural word order |
| ev_valid | output | 1 | Even-half operands valid |
| ev_data | output | NPT/2*WID | Even-half operands, lane k |
| od_valid | output | 1 | Odd-half operands valid |
| od_data | output | NPT/2*WID | Odd-half operands, lane k |
| dim_sel | output | NSEL | Pass select per datapath stage; bit 0 is the current phase |

## Verification
The bench goes after lane steering that is off by one: swapped even and odd words would send pass-one odd data to the even half, and this shows up as a mismatch against the expected row. It goes after transposition errors, where a bank indexed row-for-column would issue fed-back rows instead of columns. It stresses the ping-pong hand-off with back-to-back blocks, where a design that frees a bank too early would take a third block's row while the oldest block is still being read. Random `blk_start` pulses and input gaps target phase slips that would drop or repeat a row's odd half.

// File: rtl/twopass_pkg.sv
`timescale 1ns/1ps
package twopass_pkg;
  // Phase 0: first pass on even half, second pass on odd half.
  // Phase 1: first pass on odd half, second pass on even half.
  typedef enum logic {PH_ROW_EVEN = 1'b0, PH_ROW_ODD = 1'b1} phase_e;
endpackage

// File: rtl/twopass_halfsel.sv
`timescale 1ns/1ps
// Two-source, eight-to-four word selector: picks one source, then its
// even-indexed or odd-indexed words.
module twopass_halfsel #(
  parameter int NPT = 8,
  parameter int WID = 16
) (
  input  logic [NPT-1:0][WID-1:0]   src_a,
  input  logic [NPT-1:0][WID-1:0]   src_b,
  input  logic                      use_b,
  input  logic                      pick_odd,
  output logic [NPT/2-1:0][WID-1:0] half
);
  localparam int HALF = NPT / 2;

  logic [NPT-1:0][WID-1:0] src;
  assign src = use_b ? src_b : src_a;

  for (genvar k = 0; k < HALF; k++) begin : g_lane
    assign half[k] = pick_odd ? src[2*k+1] : src[2*k];
  end
endmodule

// File: rtl/twopass_phase.sv
`timescale 1ns/1ps
module twopass_phase
  import twopass_pkg::*;
#(
  parameter int NSEL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_start,
  input  logic            advance,
  output phase_e          ph,
  output logic [NSEL-1:0] sel
);
  phase_e            ph_q;
  logic [NSEL-2:0]   hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_ROW_EVEN;
      hist <= '0;
    end else begin
      if (blk_start)                ph_q <= PH_ROW_EVEN;
      else if (ph_q == PH_ROW_ODD)  ph_q <= PH_ROW_EVEN;
      else if (advance)             ph_q <= PH_ROW_ODD;
      hist[0] <= ph_q;
      for (int i = 1; i < NSEL - 1; i++) hist[i] <= hist[i-1];
    end
  end

  assign ph  = ph_q;
  assign sel = {hist, ph_q};

  // R8: realignment pulse lands the next cycle in phase 0
  a_r8_start_realign: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> ph_q == PH_ROW_EVEN);
  // R7: an odd phase never lasts two cycles
  a_r7_odd_returns: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_ROW_ODD |=> ph_q == PH_ROW_EVEN);
  // R9: stage selects are delayed copies of the phase
  a_r9_sel_delay: assert property (@(posedge clk) disable iff (!rst_n)
    sel[1] == $past(sel[0]));
endmodule

// File: rtl/twopass_tbuf.sv
`timescale 1ns/1ps
// Two-bank transpose store: rows written in, columns read out.
module twopass_tbuf #(
  parameter int NPT = 8,
  parameter int WID = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [NPT-1:0][WID-1:0] wr_row,
  input  logic                    rd_en,
  output logic [NPT-1:0][WID-1:0] rd_col,
  output logic                    rd_avail,
  output logic                    rd_last
);
  localparam int CW = $clog2(NPT);

  logic [WID-1:0] mem [2][NPT][NPT];
  logic           wr_sel, rd_sel;
  logic [CW-1:0]  wr_cnt, col_cnt;
  logic [1:0]     full, full_n;
  logic           wr_wrap;

  assign wr_wrap  = wr_en && (wr_cnt == CW'(NPT-1));
  assign rd_avail = full[rd_sel];
  assign rd_last  = rd_en && (col_cnt == CW'(NPT-1));

  for (genvar r = 0; r < NPT; r++) begin : g_col
    assign rd_col[r] = mem[rd_sel][r][col_cnt];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int c = 0; c < NPT; c++) mem[wr_sel][wr_cnt][c] <= wr_row[c];
    end
  end

  always_comb begin
    full_n = full;
    if (rd_last) full_n[rd_sel] = 1'b0;
    if (wr_wrap) full_n[wr_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sel  <= 1'b0;
      rd_sel  <= 1'b0;
      wr_cnt  <= '0;
      col_cnt <= '0;
      full    <= '0;
    end else begin
      full <= full_n;
      if (wr_en) begin
        if (wr_wrap) begin
          wr_cnt <= '0;
          wr_sel <= ~wr_sel;
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end
      if (rd_en) begin
        if (rd_last) begin
          col_cnt <= '0;
          rd_sel  <= ~rd_sel;
        end else begin
          col_cnt <= col_cnt + 1'b1;
        end
      end
    end
  end

  // R6: a fed-back row never lands in a bank still waiting to be read
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full[wr_sel]);
  // R5: columns are only read from a completely written bank
  a_r5_read_full: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> full[rd_sel]);
endmodule

// File: rtl/twopass_sched.sv
`timescale 1ns/1ps
module twopass_sched
  import twopass_pkg::*;
#(
  parameter int NPT  = 8,
  parameter int WID  = 16,
  parameter int NSEL = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      blk_start,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NPT-1:0][WID-1:0]   in_row,
  input  logic                      fb_valid,
  input  logic [NPT-1:0][WID-1:0]   fb_row,
  output logic                      ev_valid,
  output logic [NPT/2-1:0][WID-1:0] ev_data,
  output logic                      od_valid,
  output logic [NPT/2-1:0][WID-1:0] od_data,
  output logic [NSEL-1:0]           dim_sel
);
  localparam int CW = $clog2(NPT);

  phase_e                  ph;
  logic                    odd_ph;
  logic [NPT-1:0][WID-1:0] row_hold, col_hold, rd_col;
  logic                    row_v, col_v;
  logic [CW-1:0]           acc_cnt;
  logic [1:0]              free_cnt;
  logic                    acc, take, rd_en, rd_avail, rd_last, advance;

  assign odd_ph   = (ph == PH_ROW_ODD);
  assign in_ready = !odd_ph && !row_v && ((acc_cnt != '0) || (free_cnt != '0));
  assign acc      = in_valid && in_ready;
  assign take     = acc && (acc_cnt == '0);
  assign rd_en    = odd_ph && rd_avail;
  assign advance  = acc || row_v || col_v || rd_avail;

  twopass_phase #(.NSEL(NSEL)) u_phase (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .advance(advance),
    .ph(ph), .sel(dim_sel)
  );

  twopass_tbuf #(.NPT(NPT), .WID(WID)) u_tbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(fb_valid), .wr_row(fb_row),
    .rd_en(rd_en), .rd_col(rd_col), .rd_avail(rd_avail), .rd_last(rd_last)
  );

  // Even half: new row (phase 0) or fresh column (phase 1)
  twopass_halfsel #(.NPT(NPT), .WID(WID)) u_ev_sel (
    .src_a(in_row), .src_b(rd_col), .use_b(odd_ph), .pick_odd(1'b0),
    .half(ev_data)
  );
  // Odd half: held column (phase 0) or held row (phase 1)
  twopass_halfsel #(.NPT(NPT), .WID(WID)) u_od_sel (
    .src_a(col_hold), .src_b(row_hold), .use_b(odd_ph), .pick_odd(1'b1),
    .half(od_data)
  );

  assign ev_valid = odd_ph ? rd_en : acc;
  assign od_valid = odd_ph ? row_v : col_v;

  always_ff @(posedge clk) begin
    if (acc)   row_hold <= in_row;
    if (rd_en) col_hold <= rd_col;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_v    <= 1'b0;
      col_v    <= 1'b0;
      acc_cnt  <= '0;
      free_cnt <= 2'd2;
    end else begin
      if (acc)         row_v <= 1'b1;
      else if (odd_ph) row_v <= 1'b0;
      col_v <= rd_en;
      if (acc) acc_cnt <= (acc_cnt == CW'(NPT-1)) ? '0 : acc_cnt + 1'b1;
      free_cnt <= free_cnt - 2'(take) + 2'(rd_last);
    end
  end

  // R3: an accepted row's odd half follows in the next cycle
  a_r3_odd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !blk_start) |=> (od_valid && odd_ph));
  // R2: a column read in phase 1 delivers its odd rows in phase 0 next
  a_r2_col_odd_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (od_valid && !odd_ph));
  // R6: never more than two banks of credit
  a_r6_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= 2'd2);
  // R4: no new row while the previous row's odd half is pending
  a_r4_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (row_v && !odd_ph) |-> !in_ready);
endmodule

// File: tb/twopass_sched_bench.sv
`timescale 1ns/1ps
module twopass_sched_bench;
  localparam int NPT = 8, WID = 16, HALF = 4, NSEL = 3;
  localparam int NBLK = 24, NROWS = NBLK * NPT, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0, blk_start = 1'b0, in_valid = 1'b0, fb_valid = 1'b0;
  logic in_ready, ev_valid, od_valid;
  logic [NPT-1:0][WID-1:0]  in_row = '0, fb_row = '0;
  logic [HALF-1:0][WID-1:0] ev_data, od_data;
  logic [NSEL-1:0]          dim_sel;

  always #2.5 clk = ~clk;

  twopass_sched #(.NPT(NPT), .WID(WID), .NSEL(NSEL)) u_twopass_sched (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_row(in_row), .fb_valid(fb_valid), .fb_row(fb_row),
    .ev_valid(ev_valid), .ev_data(ev_data), .od_valid(od_valid), .od_data(od_data),
    .dim_sel(dim_sel)
  );

  int n_chk = 0, n_err = 0;
  logic [WID-1:0] rows [NROWS][NPT];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected operand words computed from the stimulus rows
  function automatic logic [WID-1:0] exp_row_word(input int r, input int w);
    return rows[r][w];
  endfunction
  function automatic logic [WID-1:0] exp_col_word(input int colidx, input int r);
    return rows[(colidx / NPT) * NPT + r][colidx % NPT];
  endfunction

  // Monitor and datapath stub
  int  p1e = 0, p1o = 0, p2 = 0, acc_n = 0, cyc = 0;
  bit  prv0 = 0, prv1 = 0, prv_busy = 0, prv_start = 0, overlap = 0;
  logic [HALF-1:0][WID-1:0] e1;
  logic                     pend_v [8];
  logic [NPT-1:0][WID-1:0]  pend_d [8];

  initial for (int i = 0; i < 8; i++) pend_v[i] = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(dim_sel[1] == prv0, "R9", "stage-1 select", dim_sel[1], prv0);
      chk(dim_sel[2] == prv1, "R9", "stage-2 select", dim_sel[2], prv1);
      if (prv_busy && !prv_start)
        chk(dim_sel[0] != prv0, "R7", "phase toggle", dim_sel[0], !prv0);
      if (prv_start)
        chk(dim_sel[0] == 1'b0, "R8", "phase after start", dim_sel[0], 0);
      if (in_ready)
        chk(dim_sel[0] == 1'b0, "R4", "ready only in phase 0", dim_sel[0], 0);

      // first pass, even half
      if (ev_valid && !dim_sel[0]) begin
        for (int k = 0; k < HALF; k++)
          if (p1e < NROWS && ev_data[k] != exp_row_word(p1e, 2*k))
            chk(0, "R2", "row even word", ev_data[k], exp_row_word(p1e, 2*k));
        chk(p1e < NROWS, "R4", "extra row even half", p1e, NROWS);
        e1 = ev_data;
        p1e++;
      end
      // first pass, odd half
      if (od_valid && dim_sel[0]) begin
        chk(p1o + 1 == p1e, "R4", "odd half pairing", p1o + 1, p1e);
        for (int k = 0; k < HALF; k++)
          if (p1o < NROWS && od_data[k] != exp_row_word(p1o, 2*k+1))
            chk(0, "R3", "row odd word", od_data[k], exp_row_word(p1o, 2*k+1));
        n_chk++;
        for (int k = 0; k < HALF; k++) begin
          pend_d[(cyc + LAT) % 8][2*k]   = e1[k];
          pend_d[(cyc + LAT) % 8][2*k+1] = od_data[k];
        end
        pend_v[(cyc + LAT) % 8] = 1'b1;
        p1o++;
      end
      // second pass, even half
      if (ev_valid && dim_sel[0]) begin
        for (int k = 0; k < HALF; k++)
          if (ev_data[k] != exp_col_word(p2, 2*k))
            chk(0, "R3", "column even word", ev_data[k], exp_col_word(p2, 2*k));
        n_chk++;
      end
      // second pass, odd half
      if (od_valid && !dim_sel[0]) begin
        for (int k = 0; k < HALF; k++)
          if (od_data[k] != exp_col_word(p2, 2*k+1))
            chk(0, "R5", "column odd word", od_data[k], exp_col_word(p2, 2*k+1));
        n_chk++;
        p2++;
      end
      // acceptance and bank credit
      if (in_valid && in_ready) begin
        if (acc_n % NPT == 0 && acc_n >= 2 * NPT)
          chk(p2 >= (acc_n / NPT - 1) * NPT, "R6", "bank reuse too early",
              p2, (acc_n / NPT - 1) * NPT);
        if (acc_n == NPT && p2 == 0) overlap = 1;
        acc_n++;
      end
      // stub feedback for the next edge
      fb_valid = pend_v[cyc % 8];
      fb_row   = pend_d[cyc % 8];
      pend_v[cyc % 8] = 1'b0;

      prv1      = prv0;
      prv0      = dim_sel[0];
      prv_busy  = ev_valid || od_valid;
      prv_start = blk_start;
    end
  end

  int ri = 0;
  int tmo = 0;
  int seed_dummy;

  initial begin
    seed_dummy = $urandom(32'd5150);
    for (int r = 0; r < NROWS; r++)
      for (int w = 0; w < NPT; w++) rows[r][w] = WID'($urandom);

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(!ev_valid && !od_valid, "R1", "no operands after reset", ev_valid | od_valid, 0);
    chk(dim_sel == '0, "R1", "selects after reset", dim_sel, 0);

    // idle: phase must hold at 0
    repeat (5) begin
      @(negedge clk);
      chk(dim_sel[0] == 1'b0, "R7", "idle phase hold", dim_sel[0], 0);
    end
    @(posedge clk); #1 blk_start = 1'b1;
    @(posedge clk); #1 blk_start = 1'b0;

    // two back-to-back blocks, then random traffic with start pulses
    while (ri < NROWS) begin
      @(posedge clk); #1;
      if (ri < 2 * NPT) begin
        in_valid  = 1'b1;
        blk_start = 1'b0;
      end else begin
        in_valid  = ($urandom % 10) < 7;
        blk_start = ($urandom % 16) == 0;
      end
      in_row = '0;
      for (int w = 0; w < NPT; w++) in_row[w] = rows[ri][w];
      @(negedge clk);
      if (in_valid && in_ready) ri++;
    end
    @(posedge clk); #1 in_valid = 1'b0; blk_start = 1'b0;

    while (p2 < NROWS && tmo < 20000) begin
      @(negedge clk);
      tmo++;
    end
    chk(tmo < 20000, "R5", "drain watchdog", p2, NROWS);
    chk(p1o == NROWS, "R4", "rows issued", p1o, NROWS);
    chk(p2 == NROWS, "R5", "columns issued", p2, NROWS);
    chk(overlap, "R6", "second block taken during first readout", overlap, 1);
    repeat (4) begin
      @(negedge clk);
      chk(dim_sel[0] == 1'b0 && in_ready, "R7", "drained hold", dim_sel[0], 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R4 watchdog expired: actual %0d expected %0d", p2, NROWS);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule